// File: doc/BRIEF.md
# Sparse Hit-Pattern Recorder

This block watches one row of 42 binary hit lines. On every bunch-crossing strobe it captures the whole row together with the current value of a 13-bit crossing counter. It then walks the row as seven groups of six lines each, lowest group first, and takes one group per clock. A group that holds at least one set line becomes a record of three fields: the captured counter value, the group number and the six-bit pattern of that group. Groups with no set line are skipped and take no storage.

Records go into a bank of 19 write-once slots, always into the lowest free slot. When a record arrives and every slot is taken, the record is discarded and a sticky overflow flag rises. A clear input empties the bank and drops the flag. A test mode makes every group look fully hit, so a few strobes fill the bank with known records. After a bunch train, a readout pass sends the written slots in slot order over a valid/ready stream and marks the final record. Slots that hold nothing are skipped.

Top module: `hit_row_recorder`

## Requirements
- R1: After reset, overflow is 0, out_valid is 0, and a readout pass returns no record.
- R2: The crossing counter is 13 bits wide and advances by one on each strobe, wrapping from 8191 to 0. A train_start pulse sets it to 0. A record carries the counter value held just before the advance of its own strobe.
- R3: Hit line i belongs to group i/6 and sits at bit i mod 6 of that group's pattern. The records from one strobe appear in ascending group order.
- R4: A group whose six lines are all 0 produces no record.
- R5: Records fill slots 0, 1, 2, ... in arrival order. Each slot is written once between clears, and the bank holds 19 records.
- R6: A non-empty group that arrives while all 19 slots are used is dropped. The overflow flag rises and stays at 1 until clear. The stored records do not change.
- R7: A clear pulse empties the bank and sets overflow to 0. The next readout then returns nothing.
- R8: A rd_start pulse begins a readout. Each beat with out_valid and out_ready both high hands over one record. out_last is 1 only on the final written slot, and out_valid is 0 after that beat.
- R9: With override_en high at a strobe, all seven groups are recorded with pattern 6'b111111, whatever the hit lines hold.
- R10: While out_valid is 1 and out_ready is 0, out_valid and the record fields hold their values.
- R11: The groups of one strobe are all stored within 8 clock cycles of the strobe edge, so a readout started then sees every one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and storage clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bx_strobe | input | 1 | One-cycle bunch-crossing pulse that captures the row |
| train_start | input | 1 | Sets the crossing counter to 0 |
| override_en | input | 1 | Test mode: every group counts as fully hit |
| hits_in | input | 42 | Binary hit lines of the row |
| clear | input | 1 | Empties the bank and clears overflow |
| rd_start | input | 1 | Starts a readout pass from slot 0 |
| out_ready | input | 1 | Consumer accepts the presented record |
| out_valid | output | 1 | A written slot is presented |
| out_last | output | 1 | The presented record is the final written one |
| out_ts | output | 13 | Counter value of the presented record |
| out_grp | output | 3 | Group number of the presented record |
| out_pat | output | 6 | Six-bit hit pattern of the presented record |
| overflow | output | 1 | Sticky flag: a record was dropped because the bank was full |

## Verification
The assertions assume that strobes are single-cycle pulses at least eight clocks apart, so that a new capture never lands while a scan is still running. They also assume that readout passes happen between strobes. The stimulus drives every strobe through one task that waits out a full scan before it returns. Readout passes start only after that task has finished, and clear is pulsed only while the stream is idle.

// File: rtl/hrr_pkg.sv
package hrr_pkg;

  localparam int unsigned HRR_HITS  = 42;
  localparam int unsigned HRR_GRP_W = 6;
  localparam int unsigned HRR_SLOTS = 19;
  localparam int unsigned HRR_TS_W  = 13;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

endpackage

// File: rtl/hrr_timebase.sv
module hrr_timebase #(
  parameter int unsigned TS_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bx_strobe,
  input  logic            train_start,
  output logic [TS_W-1:0] ts_snap
);

  logic [TS_W-1:0] ts_q, ts_d;
  logic [TS_W-1:0] snap_q, snap_d;
  logic [TS_W-1:0] ts_base;

  always_comb begin
    ts_base = train_start ? '0 : ts_q;
    ts_d    = ts_q;
    snap_d  = snap_q;
    if (train_start) ts_d = '0;
    if (bx_strobe) begin
      ts_d   = ts_base + 1'b1;
      snap_d = ts_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q   <= '0;
      snap_q <= '0;
    end else begin
      ts_q   <= ts_d;
      snap_q <= snap_d;
    end
  end

  assign ts_snap = snap_q;

  // R2: the counter steps by one per strobe
  assert_ts_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_strobe && !train_start) |=> ts_q == TS_W'($past(ts_q) + 1'b1));

  // R2: the counter holds between strobes
  assert_ts_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bx_strobe && !train_start) |=> $stable(ts_q));

  // R2: the captured value is the counter before it advances
  assert_snap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_strobe && !train_start) |=> ts_snap == $past(ts_q));

endmodule

// File: rtl/hrr_group_scan.sv
module hrr_group_scan
  import hrr_pkg::*;
#(
  parameter int unsigned N_HITS = 42,
  parameter int unsigned GRP_W  = 6,
  localparam int unsigned N_GRP = N_HITS / GRP_W,
  localparam int unsigned GA_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bx_strobe,
  input  logic              override_en,
  input  logic [N_HITS-1:0] hits_in,
  input  logic              abort,
  output logic              rec_valid,
  output logic [GA_W-1:0]   rec_grp,
  output logic [GRP_W-1:0]  rec_pat
);

  localparam logic [GA_W-1:0] LAST_GRP = GA_W'(N_GRP - 1);

  logic [N_HITS-1:0] hit_q, hit_d;
  scan_state_e       st_q, st_d;
  logic [GA_W-1:0]   grp_q, grp_d;
  logic [GRP_W-1:0]  grp_pat [N_GRP];

  for (genvar g = 0; g < N_GRP; g++) begin : g_slice
    assign grp_pat[g] = hit_q[g*GRP_W +: GRP_W];
  end

  always_comb begin
    hit_d = hit_q;
    st_d  = st_q;
    grp_d = grp_q;
    if (abort) begin
      st_d  = SCAN_IDLE;
      grp_d = '0;
    end else if (bx_strobe) begin
      hit_d = override_en ? {N_HITS{1'b1}} : hits_in;
      st_d  = SCAN_RUN;
      grp_d = '0;
    end else if (st_q == SCAN_RUN) begin
      if (grp_q == LAST_GRP) begin
        st_d  = SCAN_IDLE;
        grp_d = '0;
      end else begin
        grp_d = grp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      st_q  <= SCAN_IDLE;
      grp_q <= '0;
    end else begin
      hit_q <= hit_d;
      st_q  <= st_d;
      grp_q <= grp_d;
    end
  end

  assign rec_pat   = grp_pat[grp_q];
  assign rec_grp   = grp_q;
  assign rec_valid = (st_q == SCAN_RUN) && (|rec_pat);

  // R11: strobes never arrive while a scan is running
  assert_strobe_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bx_strobe |-> st_q == SCAN_IDLE);

  // R3: a scan starts at group 0 and steps upward
  assert_scan_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SCAN_RUN && grp_q != LAST_GRP && !abort && !bx_strobe)
      |=> st_q == SCAN_RUN && grp_q == $past(grp_q) + 1'b1);

  // R11: the scan ends after the last group
  assert_scan_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SCAN_RUN && grp_q == LAST_GRP && !bx_strobe) |=> st_q == SCAN_IDLE);

  // R3: the group index stays in range
  assert_grp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grp_q <= LAST_GRP);

endmodule

// File: rtl/hrr_slot_bank.sv
module hrr_slot_bank #(
  parameter int unsigned N_SLOTS = 19,
  parameter int unsigned TS_W    = 13,
  parameter int unsigned GA_W    = 3,
  parameter int unsigned GRP_W   = 6,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_req,
  input  logic [TS_W-1:0]  wr_ts,
  input  logic [GA_W-1:0]  wr_grp,
  input  logic [GRP_W-1:0] wr_pat,
  input  logic             rd_start,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic [TS_W-1:0]  out_ts,
  output logic [GA_W-1:0]  out_grp,
  output logic [GRP_W-1:0] out_pat,
  output logic             overflow
);

  logic [TS_W-1:0]    ts_mem  [N_SLOTS];
  logic [GA_W-1:0]    grp_mem [N_SLOTS];
  logic [GRP_W-1:0]   pat_mem [N_SLOTS];

  logic [N_SLOTS-1:0] valid_q, valid_d;
  logic [SLOT_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic               ovf_q, ovf_d;
  logic               rd_act_q, rd_act_d;
  logic [SLOT_W-1:0]  rd_ptr_q, rd_ptr_d;

  logic               full, wr_en, fire;
  logic               found, more;
  logic [SLOT_W-1:0]  sel;

  assign full  = (wr_ptr_q == SLOT_W'(N_SLOTS));
  assign wr_en = wr_req && !full && !clear;

  // first written slot at or after the read pointer, and any beyond it
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (valid_q[i] && (i >= int'(rd_ptr_q))) begin
        found = 1'b1;
        sel   = SLOT_W'(i);
      end
    end
    more = 1'b0;
    for (int j = 0; j < N_SLOTS; j++) begin
      if (valid_q[j] && (j > int'(sel))) more = 1'b1;
    end
  end

  assign out_valid = rd_act_q && found;
  assign out_last  = out_valid && !more;
  assign fire      = out_valid && out_ready;
  assign out_ts    = ts_mem[sel];
  assign out_grp   = grp_mem[sel];
  assign out_pat   = pat_mem[sel];
  assign overflow  = ovf_q;

  always_comb begin
    valid_d  = valid_q;
    wr_ptr_d = wr_ptr_q;
    ovf_d    = ovf_q;
    rd_act_d = rd_act_q;
    rd_ptr_d = rd_ptr_q;
    if (clear) begin
      valid_d  = '0;
      wr_ptr_d = '0;
      ovf_d    = 1'b0;
      rd_act_d = 1'b0;
      rd_ptr_d = '0;
    end else begin
      if (wr_en) begin
        valid_d[wr_ptr_q] = 1'b1;
        wr_ptr_d          = wr_ptr_q + 1'b1;
      end
      if (wr_req && full) ovf_d = 1'b1;
      if (rd_start) begin
        rd_act_d = 1'b1;
        rd_ptr_d = '0;
      end else if (rd_act_q) begin
        if (fire) begin
          rd_ptr_d = sel + 1'b1;
          if (!more) rd_act_d = 1'b0;
        end else if (!found) begin
          rd_act_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      wr_ptr_q <= '0;
      ovf_q    <= 1'b0;
      rd_act_q <= 1'b0;
      rd_ptr_q <= '0;
    end else begin
      valid_q  <= valid_d;
      wr_ptr_q <= wr_ptr_d;
      ovf_q    <= ovf_d;
      rd_act_q <= rd_act_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  // record storage: data registers, write-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ts_mem[wr_ptr_q]  <= wr_ts;
      grp_mem[wr_ptr_q] <= wr_grp;
      pat_mem[wr_ptr_q] <= wr_pat;
    end
  end

  // R5: a slot is never written twice between clears
  assert_write_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !valid_q[wr_ptr_q]);

  // R6: a record that meets a full bank raises the flag
  assert_ovf_on_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !clear) |=> overflow);

  // R6: the flag is sticky until clear
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);

  // R7: clear empties the bank and the flag
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!overflow && !out_valid && valid_q == '0));

  // R8: last only on a presented record
  assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R8: nothing is presented after the final beat
  assert_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready && !rd_start) |=> !out_valid);

  // R10: a stalled record holds
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear && !rd_start)
      |=> (out_valid && $stable(out_ts) && $stable(out_grp) && $stable(out_pat)));

endmodule

// File: rtl/hit_row_recorder.sv
module hit_row_recorder
  import hrr_pkg::*;
#(
  parameter int unsigned N_HITS  = HRR_HITS,
  parameter int unsigned GRP_W   = HRR_GRP_W,
  parameter int unsigned N_SLOTS = HRR_SLOTS,
  parameter int unsigned TS_W    = HRR_TS_W,
  localparam int unsigned N_GRP  = N_HITS / GRP_W,
  localparam int unsigned GA_W   = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bx_strobe,
  input  logic              train_start,
  input  logic              override_en,
  input  logic [N_HITS-1:0] hits_in,
  input  logic              clear,
  input  logic              rd_start,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic [TS_W-1:0]   out_ts,
  output logic [GA_W-1:0]   out_grp,
  output logic [GRP_W-1:0]  out_pat,
  output logic              overflow
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [TS_W-1:0]  ts_snap;
  logic             rec_valid;
  logic [GA_W-1:0]  rec_grp;
  logic [GRP_W-1:0] rec_pat;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  hrr_timebase #(.TS_W(TS_W)) u_tb (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bx_strobe   (bx_strobe),
    .train_start (train_start),
    .ts_snap     (ts_snap)
  );

  hrr_group_scan #(.N_HITS(N_HITS), .GRP_W(GRP_W)) u_scan (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bx_strobe   (bx_strobe),
    .override_en (override_en),
    .hits_in     (hits_in),
    .abort       (clear),
    .rec_valid   (rec_valid),
    .rec_grp     (rec_grp),
    .rec_pat     (rec_pat)
  );

  hrr_slot_bank #(
    .N_SLOTS (N_SLOTS),
    .TS_W    (TS_W),
    .GA_W    (GA_W),
    .GRP_W   (GRP_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear     (clear),
    .wr_req    (rec_valid),
    .wr_ts     (ts_snap),
    .wr_grp    (rec_grp),
    .wr_pat    (rec_pat),
    .rd_start  (rd_start),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ts    (out_ts),
    .out_grp   (out_grp),
    .out_pat   (out_pat),
    .overflow  (overflow)
  );

  // R4: every stored record carries at least one hit
  assert_nonzero_rec_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> out_pat != '0);

endmodule

// File: tb/sim_hit_row_recorder.sv
module sim_hit_row_recorder;

  localparam int NH = 42;
  localparam int GW = 6;
  localparam int NG = 7;
  localparam int NS = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bx_strobe = 1'b0;
  logic          train_start = 1'b0;
  logic          override_en = 1'b0;
  logic [NH-1:0] hits_in = '0;
  logic          clear = 1'b0;
  logic          rd_start = 1'b0;
  logic          out_ready = 1'b0;
  logic          out_valid, out_last, overflow;
  logic [12:0]   out_ts;
  logic [2:0]    out_grp;
  logic [5:0]    out_pat;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [12:0] model_ts = '0;
  logic        exp_ovf = 1'b0;
  int          exp_n = 0;
  logic [12:0] e_ts  [NS];
  logic [2:0]  e_grp [NS];
  logic [5:0]  e_pat [NS];
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  hit_row_recorder u0 (
    .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .train_start(train_start),
    .override_en(override_en), .hits_in(hits_in), .clear(clear),
    .rd_start(rd_start), .out_ready(out_ready), .out_valid(out_valid),
    .out_last(out_last), .out_ts(out_ts), .out_grp(out_grp),
    .out_pat(out_pat), .overflow(overflow)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    exp_n = 0;
    exp_ovf = 1'b0;
  endtask

  task automatic do_train();
    @(negedge clk); train_start = 1'b1;
    @(negedge clk); train_start = 1'b0;
    model_ts = '0;
  endtask

  // model and drive one strobe; returns after the full scan window
  task automatic do_strobe(input logic [NH-1:0] h, input logic ovr);
    for (int g = 0; g < NG; g++) begin
      logic [5:0] p;
      p = ovr ? 6'h3f : h[g*GW +: GW];
      if (p != 6'h0) begin
        if (exp_n < NS) begin
          e_ts[exp_n]  = model_ts;
          e_grp[exp_n] = 3'(g);
          e_pat[exp_n] = p;
          exp_n = exp_n + 1;
        end else begin
          exp_ovf = 1'b1;
        end
      end
    end
    model_ts = model_ts + 13'd1;
    @(negedge clk);
    bx_strobe = 1'b1; hits_in = h; override_en = ovr;
    @(negedge clk);
    bx_strobe = 1'b0; hits_in = '0; override_en = 1'b0;
    repeat (NG) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int n;
    int cyc;
    bit done;
    n = 0; cyc = 0; done = 0;
    @(negedge clk); rd_start = 1'b1; out_ready = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    while (!done && cyc < 60) begin
      if (out_valid) begin
        if (n < exp_n) begin
          chk(out_ts == e_ts[n], req, "record timestamp", int'(out_ts), int'(e_ts[n]));
          chk(out_grp == e_grp[n], req, "record group", int'(out_grp), int'(e_grp[n]));
          chk(out_pat == e_pat[n], req, "record pattern", int'(out_pat), int'(e_pat[n]));
          chk(out_last == (n == exp_n - 1), "R8", "last flag", int'(out_last), int'(n == exp_n - 1));
        end
        n = n + 1;
        if (out_last) done = 1;
      end
      @(negedge clk);
      cyc = cyc + 1;
      if (exp_n == 0 && cyc > 4) done = 1;
    end
    chk(n == exp_n, req, "records read out", n, exp_n);
    chk(!out_valid, "R8", "valid after pass", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    logic [NH-1:0] h;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and empty readout
    chk(overflow == 1'b0, "R1", "overflow after reset", int'(overflow), 0);
    chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    drain("R1");

    // R3: every single line alone, group and bit position
    do_train();
    for (int b = 0; b < NH; b++) begin
      do_clear();
      h = '0; h[b] = 1'b1;
      do_strobe(h, 1'b0);
      drain("R3");
    end

    // R4 R5: sparse random rows, two strobes per train
    for (int it = 0; it < 20; it++) begin
      do_clear();
      for (int s = 0; s < 2; s++) begin
        next_rand();
        h = rng[NH-1:0];
        next_rand();
        for (int g = 0; g < NG; g++) if (rng[g]) h[g*GW +: GW] = '0;
        do_strobe(h, 1'b0);
      end
      drain("R4");
    end

    // R5 R6 R9: override fills the bank then overflows
    do_clear();
    do_strobe('0, 1'b1);
    do_strobe('0, 1'b1);
    chk(overflow == 1'b0, "R5", "no overflow at 14 records", int'(overflow), 0);
    do_strobe('0, 1'b1);
    chk(overflow == exp_ovf, "R6", "overflow at 21 records", int'(overflow), int'(exp_ovf));
    drain("R9");
    do_strobe({NH{1'b1}}, 1'b0);
    chk(overflow == 1'b1, "R6", "overflow sticky", int'(overflow), 1);
    drain("R6");

    // R7: clear empties
    do_clear();
    chk(overflow == 1'b0, "R7", "overflow after clear", int'(overflow), 0);
    drain("R7");

    // R10: stall holds the presented record
    do_clear();
    h = '0; h[8] = 1'b1; h[27] = 1'b1;
    do_strobe(h, 1'b0);
    @(negedge clk); rd_start = 1'b1; out_ready = 1'b0;
    @(negedge clk); rd_start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(out_valid == 1'b1, "R10", "valid during stall", int'(out_valid), 1);
      chk(out_grp == 3'd1 && out_pat == 6'h04, "R10", "group/pattern during stall",
          int'({out_grp, out_pat}), int'({3'd1, 6'h04}));
      @(negedge clk);
    end
    drain("R10");

    // R11: readout started right after the scan window sees group 6
    do_clear();
    h = '0; h[41] = 1'b1; h[36] = 1'b1;
    do_strobe(h, 1'b0);
    drain("R11");

    // R2: train_start restarts the counter
    do_strobe('0, 1'b0);
    do_strobe('0, 1'b0);
    do_train();
    do_clear();
    h = '0; h[13] = 1'b1;
    do_strobe(h, 1'b0);
    chk(e_ts[0] == 13'd0, "R2", "model counter after train start", int'(e_ts[0]), 0);
    drain("R2");

    // R2: wrap from 8191 to 0
    do_train();
    do_clear();
    for (int s = 0; s < 8191; s++) do_strobe('0, 1'b0);
    h = '0; h[0] = 1'b1;
    do_strobe(h, 1'b0);
    h = '0; h[20] = 1'b1;
    do_strobe(h, 1'b0);
    chk(e_ts[0] == 13'd8191 && e_ts[1] == 13'd0, "R2", "model wrap values",
        int'(e_ts[1]), 0);
    drain("R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule